// File: doc/BRIEF.md
# Hint-Driven Cache Victim Selector

This block holds the tag and line-state storage of a set-associative data cache and makes all of its lookup and replacement decisions. Each request carries a byte address, a read/write flag and a one-bit eviction hint. The hint is raised by special load and store operations whose data will not be reused soon, and it is low for ordinary accesses. The block compares the request tag against every way of the indexed set and reports hit or miss. On a hit it reports the way that hit. On a miss it reports the way chosen for replacement, whether that way held a valid line, and that line's dirty status and tag, so that surrounding logic can issue a writeback. It then installs the new tag.

Every line keeps a valid bit, a dirty bit, an eviction-hint bit and a recency rank. When a set is full, the replacement choice first looks at lines whose hint bit is set and picks the least recently used of them. If no line in the set is flagged, it falls back to plain least-recently-used order. The data array, refill path and memory interface lie outside the block. The associativity is 2 or 4 ways, chosen by parameter, and the default configuration is 2 ways by 128 sets with 64-byte lines.

Top module: `hint_victim_cache`

## Requirements
- R1: A response (`rsp_valid` high) appears in exactly the cycle after a cycle with `req_valid` high. In a cycle after a cycle with `req_valid` low, `rsp_valid` is low.
- R2: A request whose tag matches a valid line of the indexed set reports `rsp_hit`=1 and gives that line's way on `rsp_way`.
- R3: On a miss in a set that still has an invalid way, the lowest-numbered invalid way is chosen, even when valid ways carry a set hint bit, and `rsp_victim_valid` is 0.
- R4: On a miss in a full set where one or more lines have the hint bit set, the victim is the least recently used of the flagged lines, even if it is more recent than an unflagged line.
- R5: On a miss in a full set with no hint bit set, the victim is the least recently used way.
- R6: On a hit, the line becomes most recently used and its hint bit is overwritten with the request's hint, so a hint can be both set and cleared.
- R7: On a miss, the new tag is written into the victim way, which becomes valid and most recently used, and its hint bit is taken from the request.
- R8: A write hit sets the line's dirty bit and a read hit leaves it unchanged. A line filled by a write miss is dirty and a line filled by a read miss is clean.
- R9: On a miss with a valid victim, `rsp_victim_valid`=1 and `rsp_victim_dirty` and `rsp_victim_tag` give that line's dirty bit and tag. On a hit, `rsp_victim_valid` and `rsp_victim_dirty` are 0.
- R10: Reset (asynchronous, active low) clears every valid, dirty and hint bit, holds `rsp_valid` low, and sets the recency order of every set so that way 0 is least recent and the highest way is most recent.
- R11: Address bits below the line offset take no part in the lookup. The set index is the `log2(SETS)` bits just above the offset, and the tag is all the bits above the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Byte address of the access |
| req_write | input | 1 | 1 = store, 0 = load |
| req_evict_hint | input | 1 | Eviction hint carried by the access |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | Request hit |
| rsp_way | output | log2(WAYS) | Hit way on a hit, replaced way on a miss |
| rsp_victim_valid | output | 1 | Replaced way held a valid line |
| rsp_victim_dirty | output | 1 | Replaced line was dirty (writeback needed) |
| rsp_victim_tag | output | ADDR_W-log2(SETS)-6 | Tag of the replaced line, zero if it was invalid |

## Verification
A corrupted recency rank or hint bit does not show up on the access that corrupts it. It shows up only on the next miss in a full set, when `rsp_way` and `rsp_victim_tag` name the wrong line. A lost dirty bit shows up only when that line is later evicted, as a missing writeback flag. For this reason the stimulus refills a few sets over and over with a small tag pool, so that every state change is followed within a few accesses by an eviction from the same set. A wrongly written tag shows up on the very next access to that line, as a hit that should be a miss or a miss that should be a hit.

// File: rtl/hvc_pkg.sv
package hvc_pkg;
  // Reason the replacement way was selected.
  typedef enum logic [1:0] {
    VSRC_NONE    = 2'd0,
    VSRC_EMPTY   = 2'd1,
    VSRC_FLAGGED = 2'd2,
    VSRC_AGE     = 2'd3
  } vsrc_e;
endpackage

// File: rtl/hvc_match.sv
module hvc_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 19,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [TAG_W-1:0]           probe_tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (way_valid[i] && (way_tag[i] == probe_tag)) begin
        hit     = 1'b1;
        hit_way = WAY_W'(i);
      end
    end
  end
endmodule

// File: rtl/hvc_victim.sv
module hvc_victim
  import hvc_pkg::*;
#(
  parameter int WAYS = 2,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0]            way_flag,
  input  logic [WAYS-1:0][WAY_W-1:0] way_age,
  output logic [WAY_W-1:0]           victim_way,
  output vsrc_e                      victim_src
);
  logic [WAYS-1:0]  cand;
  logic             found;
  logic [WAY_W-1:0] best_age;

  always_comb begin
    victim_way = '0;
    victim_src = VSRC_AGE;
    found      = 1'b0;
    best_age   = '0;
    cand       = (|way_flag) ? way_flag : {WAYS{1'b1}};
    if (!(&way_valid)) begin
      // empty way first, lowest index wins
      victim_src = VSRC_EMPTY;
      for (int i = WAYS - 1; i >= 0; i--) begin
        if (!way_valid[i]) victim_way = WAY_W'(i);
      end
    end else begin
      if (|way_flag) victim_src = VSRC_FLAGGED;
      // oldest (highest age) among the candidates
      for (int i = 0; i < WAYS; i++) begin
        if (cand[i] && (!found || (way_age[i] > best_age))) begin
          found      = 1'b1;
          best_age   = way_age[i];
          victim_way = WAY_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/hvc_age.sv
module hvc_age #(
  parameter int WAYS = 2,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][WAY_W-1:0] age_in,
  input  logic [WAY_W-1:0]           touch_way,
  output logic [WAYS-1:0][WAY_W-1:0] age_out
);
  // Age 0 = most recent, WAYS-1 = least recent; ages form a permutation.
  always_comb begin
    for (int j = 0; j < WAYS; j++) begin
      if (WAY_W'(j) == touch_way) begin
        age_out[j] = '0;
      end else if (age_in[j] < age_in[touch_way]) begin
        age_out[j] = age_in[j] + 1'b1;
      end else begin
        age_out[j] = age_in[j];
      end
    end
  end
endmodule

// File: rtl/hint_victim_cache.sv
module hint_victim_cache
  import hvc_pkg::*;
#(
  parameter int WAYS   = 2,
  parameter int SETS   = 128,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_evict_hint,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic              rsp_victim_valid,
  output logic              rsp_victim_dirty,
  output logic [TAG_W-1:0]  rsp_victim_tag
);
  // line state storage
  logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
  logic [WAYS-1:0]            valid_q [SETS];
  logic [WAYS-1:0]            dirty_q [SETS];
  logic [WAYS-1:0]            flag_q  [SETS];
  logic [WAYS-1:0][WAY_W-1:0] age_q   [SETS];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] rtag;
  logic             unused_offset;

  assign idx           = req_addr[OFF_W +: IDX_W];
  assign rtag          = req_addr[ADDR_W-1 -: TAG_W];
  assign unused_offset = ^req_addr[OFF_W-1:0];

  logic [WAYS-1:0][TAG_W-1:0] set_tag;
  logic [WAYS-1:0]            set_valid, set_dirty, set_flag;
  logic [WAYS-1:0][WAY_W-1:0] set_age;

  assign set_tag   = tag_q[idx];
  assign set_valid = valid_q[idx];
  assign set_dirty = dirty_q[idx];
  assign set_flag  = flag_q[idx];
  assign set_age   = age_q[idx];

  logic             hit;
  logic [WAY_W-1:0] hit_way, victim_way, use_way;
  vsrc_e            victim_src;

  hvc_match #(.WAYS(WAYS), .TAG_W(TAG_W)) match_i (
    .way_valid (set_valid),
    .way_tag   (set_tag),
    .probe_tag (rtag),
    .hit       (hit),
    .hit_way   (hit_way)
  );

  hvc_victim #(.WAYS(WAYS)) victim_i (
    .way_valid  (set_valid),
    .way_flag   (set_flag),
    .way_age    (set_age),
    .victim_way (victim_way),
    .victim_src (victim_src)
  );

  logic [WAYS-1:0][WAY_W-1:0] age_n;

  hvc_age #(.WAYS(WAYS)) age_i (
    .age_in    (set_age),
    .touch_way (use_way),
    .age_out   (age_n)
  );

  // next state of the indexed set and of the response
  logic [WAYS-1:0]  way_bit, valid_n, dirty_n, flag_n;
  logic             vv_d, vd_d;
  logic [TAG_W-1:0] vt_d;

  always_comb begin
    use_way          = hit ? hit_way : victim_way;
    way_bit          = '0;
    way_bit[use_way] = 1'b1;
    valid_n          = set_valid | way_bit;
    flag_n           = req_evict_hint ? (set_flag | way_bit) : (set_flag & ~way_bit);
    if (hit) begin
      dirty_n = req_write ? (set_dirty | way_bit) : set_dirty;
    end else begin
      dirty_n = req_write ? (set_dirty | way_bit) : (set_dirty & ~way_bit);
    end
    vv_d = !hit && (victim_src != VSRC_EMPTY);
    vd_d = vv_d && set_dirty[victim_way];
    vt_d = vv_d ? set_tag[victim_way] : '0;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        flag_q[s]  <= '0;
        for (int w = 0; w < WAYS; w++) begin
          age_q[s][w] <= WAY_W'(WAYS - 1 - w);
        end
      end
    end else if (req_valid) begin
      valid_q[idx] <= valid_n;
      dirty_q[idx] <= dirty_n;
      flag_q[idx]  <= flag_n;
      age_q[idx]   <= age_n;
    end
  end

  // tag storage is not reset; valid bits qualify it
  always_ff @(posedge clk) begin
    if (req_valid && !hit) begin
      tag_q[idx][use_way] <= rtag;
    end
  end

  // response registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid        <= 1'b0;
      rsp_hit          <= 1'b0;
      rsp_way          <= '0;
      rsp_victim_valid <= 1'b0;
      rsp_victim_dirty <= 1'b0;
      rsp_victim_tag   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit          <= hit;
        rsp_way          <= use_way;
        rsp_victim_valid <= vv_d;
        rsp_victim_dirty <= vd_d;
        rsp_victim_tag   <= vt_d;
      end
    end
  end
endmodule

// File: rtl/hvc_checker.sv
module hvc_checker #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_victim_valid,
  input logic              rsp_victim_dirty
);
  logic                    prev_valid;
  logic [ADDR_W-OFF_W-1:0] prev_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_valid <= 1'b0;
      prev_line  <= '0;
    end else begin
      prev_valid <= req_valid;
      prev_line  <= req_addr[ADDR_W-1:OFF_W];
    end
  end

  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_rsp_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R2 / R11: a line touched in the previous cycle is resident now
  assert_repeat_line_hits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && prev_valid && (req_addr[ADDR_W-1:OFF_W] == prev_line)) |=> rsp_hit);

  assert_hit_has_no_victim_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (!rsp_victim_valid && !rsp_victim_dirty));

  assert_dirty_victim_is_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_victim_dirty) |-> rsp_victim_valid);
endmodule

bind hint_victim_cache hvc_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) chk_i (
  .clk              (clk),
  .rst_n            (rst_n),
  .req_valid        (req_valid),
  .req_addr         (req_addr),
  .rsp_valid        (rsp_valid),
  .rsp_hit          (rsp_hit),
  .rsp_victim_valid (rsp_victim_valid),
  .rsp_victim_dirty (rsp_victim_dirty)
);

// File: tb/hint_victim_cache_tb_top.sv
module hint_victim_cache_tb_top;
  localparam int WAYS   = 2;
  localparam int SETS   = 128;
  localparam int ADDR_W = 32;
  localparam int OFF_W  = 6;
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic              rst_n;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic              req_write;
  logic              req_evict_hint;
  logic              rsp_valid;
  logic              rsp_hit;
  logic [WAY_W-1:0]  rsp_way;
  logic              rsp_victim_valid;
  logic              rsp_victim_dirty;
  logic [TAG_W-1:0]  rsp_victim_tag;

  hint_victim_cache #(.WAYS(WAYS), .SETS(SETS), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) dut_i (
    .clk, .rst_n, .req_valid, .req_addr, .req_write, .req_evict_hint,
    .rsp_valid, .rsp_hit, .rsp_way, .rsp_victim_valid, .rsp_victim_dirty, .rsp_victim_tag
  );

  // ---------------- reference model (timestamp based LRU) ----------------
  bit               mv [SETS][WAYS];
  bit               md [SETS][WAYS];
  bit               me [SETS][WAYS];
  logic [TAG_W-1:0] mt [SETS][WAYS];
  int               ms [SETS][WAYS];
  int               mnow;

  typedef struct packed {
    logic             hit;
    logic [1:0]       way;
    logic             vv;
    logic             vd;
    logic [TAG_W-1:0] vt;
  } exp_t;

  exp_t  expq [$];
  string labq [$];
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;

  task automatic model_reset();
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        mv[s][w] = 1'b0;
        md[s][w] = 1'b0;
        me[s][w] = 1'b0;
        ms[s][w] = w;          // way 0 oldest after reset (R10)
      end
    end
    mnow = WAYS;
  endtask

  // driver: drives one request at a negedge and queues the expected response
  task automatic issue(input int set, input logic [TAG_W-1:0] tg, input int off,
                       input bit wr, input bit hint, input string lbl);
    exp_t e;
    int   way;
    bit   found;
    @(negedge clk);
    req_valid      = 1'b1;
    req_addr       = {tg, IDX_W'(set), OFF_W'(off)};
    req_write      = wr;
    req_evict_hint = hint;
    e     = '0;
    found = 1'b0;
    way   = 0;
    for (int w = 0; w < WAYS; w++) begin
      if (mv[set][w] && mt[set][w] == tg) begin
        found = 1'b1;
        way   = w;
      end
    end
    if (found) begin
      e.hit = 1'b1;
      md[set][way] = md[set][way] | wr;
    end else begin
      bit any_inv, any_flag;
      int best;
      any_inv  = 1'b0;
      any_flag = 1'b0;
      for (int w = WAYS - 1; w >= 0; w--) begin
        if (!mv[set][w]) begin any_inv = 1'b1; way = w; end
        if (mv[set][w] && me[set][w]) any_flag = 1'b1;
      end
      if (!any_inv) begin
        best = -1;
        for (int w = 0; w < WAYS; w++) begin
          if ((!any_flag || me[set][w]) && (best < 0 || ms[set][w] < ms[set][best])) best = w;
        end
        way  = best;
        e.vv = 1'b1;
        e.vd = md[set][way];
        e.vt = mt[set][way];
      end
      mv[set][way] = 1'b1;
      mt[set][way] = tg;
      md[set][way] = wr;
    end
    e.way = 2'(way);
    me[set][way] = hint;
    ms[set][way] = mnow;
    mnow++;
    expq.push_back(e);
    labq.push_back(lbl);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid      = 1'b0;
    req_write      = 1'b0;
    req_evict_hint = 1'b0;
    @(posedge clk);
    #3;
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: rsp_valid=%0b expected 0 after idle cycle", rsp_valid);
    end
  endtask

  // monitor: pops and compares each response
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && rsp_valid) begin
        checks++;
        if (expq.size() == 0) begin
          fails++;
          $display("FAIL R1: unexpected response, actual rsp_valid=1 expected 0");
        end else begin
          exp_t  e;
          string l;
          bit    ok;
          e  = expq.pop_front();
          l  = labq.pop_front();
          ok = (rsp_hit === e.hit) && (2'(rsp_way) === e.way) &&
               (rsp_victim_valid === e.vv) && (rsp_victim_dirty === e.vd) &&
               (!e.vv || rsp_victim_tag === e.vt);
          if (!ok) begin
            fails++;
            $display("FAIL %s: actual hit=%0b way=%0d vv=%0b vd=%0b vt=%h expected hit=%0b way=%0d vv=%0b vd=%0b vt=%h",
                     l, rsp_hit, rsp_way, rsp_victim_valid, rsp_victim_dirty, rsp_victim_tag,
                     e.hit, e.way, e.vv, e.vd, e.vt);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n          = 1'b0;
    req_valid      = 1'b0;
    req_addr       = '0;
    req_write      = 1'b0;
    req_evict_hint = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #3;
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R10: rsp_valid=%0b expected 0 after reset", rsp_valid);
    end

    // R3 / R7: empty ways filled in index order
    issue(5, 19'h0A1, 0, 0, 0, "R3");
    issue(5, 19'h0B2, 0, 0, 0, "R3");
    // R2 / R8 / R11: write hit at another offset in the same line
    issue(5, 19'h0A1, 37, 1, 0, "R11");
    // R5 / R9: LRU victim (B), clean
    issue(5, 19'h0C3, 0, 0, 0, "R5");
    // R6: hit sets the hint on A (A now most recent)
    issue(5, 19'h0A1, 4, 0, 1, "R6");
    // R4 / R9: flagged A evicted despite being most recent; dirty
    issue(5, 19'h0D4, 0, 0, 0, "R4");
    idle();

    // R3: an empty way wins over a flagged valid way
    issue(9, 19'h111, 0, 0, 1, "R7");
    issue(9, 19'h122, 0, 0, 0, "R3");
    // R4: flagged fill is the victim
    issue(9, 19'h133, 0, 0, 0, "R4");

    // R6: hit clears the hint again
    issue(12, 19'h201, 0, 0, 1, "R7");
    issue(12, 19'h202, 0, 0, 0, "R3");
    issue(12, 19'h201, 0, 0, 0, "R6");
    issue(12, 19'h203, 0, 0, 0, "R6");
    idle();

    // R8: write-miss fill is dirty, read hit keeps it
    issue(20, 19'h301, 0, 1, 0, "R8");
    issue(20, 19'h302, 0, 0, 0, "R8");
    issue(20, 19'h301, 0, 0, 0, "R8");
    issue(20, 19'h302, 0, 0, 0, "R8");
    issue(20, 19'h303, 0, 0, 0, "R8");

    // R4: two flagged lines, the older one goes
    issue(30, 19'h401, 0, 0, 1, "R4");
    issue(30, 19'h402, 0, 0, 1, "R4");
    issue(30, 19'h401, 0, 0, 1, "R4");
    issue(30, 19'h403, 0, 0, 0, "R4");
    idle();

    // mixed stream over two sets with a small tag pool
    for (int n = 0; n < 1500; n++) begin
      int s;
      s = 3 + ($urandom % 2);
      issue(s, 19'(($urandom % 5) + 1), int'($urandom % 64),
            bit'($urandom % 2), ($urandom % 4) == 0, "R5");
      if (($urandom % 8) == 0) idle();
    end
    idle();

    // R10: reset in mid run empties the cache and restores way 0 as oldest
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #3;
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R10: rsp_valid=%0b expected 0 after reset", rsp_valid);
    end
    issue(5, 19'h0C3, 0, 0, 0, "R10");
    issue(5, 19'h0C3, 0, 0, 0, "R10");
    issue(5, 19'h0E5, 0, 0, 0, "R10");
    issue(5, 19'h0F6, 0, 0, 0, "R10");
    idle();
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule